// File: doc/BRIEF.md
# QPSK Carrier Phase and Frequency Tracker

This block keeps a receiver's local oscillator aligned with a transmitter that runs from its own crystal. For each received symbol it takes a measured carrier angle and discards the two quadrant bits, which carry the data. It adds up the remaining sub-quadrant fraction over the four symbols of one byte. When the byte ends it compares the mean fraction with the mid-quadrant point. The difference is a phase error. The error moves a phase offset word by a proportional step. From the second byte after a restart, it also moves a saturating frequency-trim integrator. The loop therefore acts as a second-order PLL that updates once per byte.

Angles enter on a valid/ready stream. The block accepts symbols while `ang_ready` is high. Once a full byte has been accepted, `ang_ready` stays low until the byte strobe applies the correction. While `ang_ready` is low, an offered symbol is held off and not consumed, so the upstream stage must keep `ang_valid` and `ang_data` steady until the handshake completes. The byte strobe and the resync input are plain control pins. The phase offset feeds the NCO phase input. The trim is added to the NCO tuning word, so both corrections take effect before the next byte.

Top module: `carrier_tracker`

## Requirements
- R1: After reset, `phase_ofs` is 0, `freq_trim` is 0 and `ang_ready` is 1.
- R2: A symbol is taken on a clock edge where `ang_valid` and `ang_ready` are both high. After the fourth symbol is taken, `ang_ready` is low until an accepted byte strobe. Symbols offered while `ang_ready` is low are not taken and do not affect the result.
- R3: The two most significant angle bits (bits 15:14, the quadrant) have no effect on either correction.
- R4: The byte error is floor((sum of the four 14-bit fractions, bits 13:0) / 4) minus 8192. Its range is -8192 to 8191.
- R5: On a clock edge where `byte_strobe` is high and four symbols are held, `phase_ofs` becomes `phase_ofs` plus (error >>> 1), using an arithmetic shift and taken modulo 65536.
- R6: On that same edge, except on the first byte after a reset or resync, `freq_trim` becomes `freq_trim` plus (error >>> 4), saturated to the 12-bit signed range -2048 to 2047.
- R7: The first byte applied after a reset or resync changes `phase_ofs` only. `freq_trim` stays unchanged.
- R8: A byte strobe while fewer than four symbols are held is ignored. Both outputs stay unchanged, and the symbols already held count toward the next byte.
- R9: Resync clears `freq_trim` to 0 on the next edge. It discards the held symbols and raises `ang_ready`. It keeps `phase_ofs` and re-arms the first-byte rule.
- R10: Outputs change only on an accepted byte strobe or on resync. Accepting symbols alone leaves them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| resync | input | 1 | Clears the integrator and the held symbols and restarts acquisition |
| ang_valid | input | 1 | Angle word is offered |
| ang_ready | output | 1 | Block can take an angle word |
| ang_data | input | 16 | Measured carrier angle, full turn = 65536 |
| byte_strobe | input | 1 | Byte boundary; applies the correction when four symbols are held |
| phase_ofs | output | 16 | Accumulated phase offset for the NCO |
| freq_trim | output | 12 | Signed tuning-word adjustment |

## Verification
A symbol counts as taken on the rising edge where it is handshaked. `ang_ready` falls on the same edge that takes the fourth symbol. Both correction outputs are registered once, so they carry the new values right after the edge that samples the strobe with four symbols held. A resync clears `freq_trim` on the edge that samples it. The bench drives inputs on the falling edge and reads results on the next falling edge. Each result is therefore checked half a cycle after the edge that produced it. The checks around a strobe with too few symbols, and around symbols held off during back-pressure, look at both outputs before the next byte is applied.

// File: rtl/trk_pkg.sv
package trk_pkg;
  typedef enum logic {
    LOOP_ACQ,
    LOOP_TRACK
  } loop_mode_e;
endpackage

// File: rtl/trk_frac_avg.sv
module trk_frac_avg #(
  parameter int FRAC_W = 14,
  parameter int SYMS   = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                take,
  input  logic [FRAC_W-1:0]   frac,
  output logic                full,
  output logic signed [FRAC_W:0] err
);
  localparam int SH    = $clog2(SYMS);
  localparam int SUM_W = FRAC_W + SH;
  localparam int CNT_W = $clog2(SYMS + 1);
  localparam logic [FRAC_W-1:0] TARGET = FRAC_W'(1) << (FRAC_W - 1);

  logic [SUM_W-1:0] sum_q;
  logic [CNT_W-1:0] cnt_q;

  assign full = (cnt_q == CNT_W'(SYMS));

  always_comb begin
    err = $signed({1'b0, sum_q[SUM_W-1:SH]}) - $signed({1'b0, TARGET});
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      sum_q <= '0;
      cnt_q <= '0;
    end else if (take) begin
      sum_q <= sum_q + SUM_W'(frac);
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/trk_loop_filter.sv
module trk_loop_filter
  import trk_pkg::*;
#(
  parameter int ANG_W    = 16,
  parameter int ERR_W    = 15,
  parameter int TRIM_W   = 12,
  parameter int KP_SHIFT = 1,
  parameter int KI_SHIFT = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     resync,
  input  logic                     apply,
  input  logic signed [ERR_W-1:0]  err,
  output logic [ANG_W-1:0]         phase_ofs,
  output logic signed [TRIM_W-1:0] freq_trim
);
  localparam int SW = ((ERR_W > TRIM_W) ? ERR_W : TRIM_W) + 1;
  localparam logic signed [SW-1:0] T_MAX = SW'((1 <<< (TRIM_W - 1)) - 1);
  localparam logic signed [SW-1:0] T_MIN = SW'(-(1 <<< (TRIM_W - 1)));

  loop_mode_e mode_q;
  logic signed [ERR_W-1:0] p_step, i_step;
  logic signed [SW-1:0]    t_sum;
  logic signed [TRIM_W-1:0] t_next;

  always_comb begin
    p_step = err >>> KP_SHIFT;
    i_step = err >>> KI_SHIFT;
    t_sum  = SW'(freq_trim) + SW'(i_step);
    if (t_sum > T_MAX)      t_next = TRIM_W'(T_MAX);
    else if (t_sum < T_MIN) t_next = TRIM_W'(T_MIN);
    else                    t_next = TRIM_W'(t_sum);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_ofs <= '0;
      freq_trim <= '0;
      mode_q    <= LOOP_ACQ;
    end else if (resync) begin
      freq_trim <= '0;
      mode_q    <= LOOP_ACQ;
    end else if (apply) begin
      phase_ofs <= phase_ofs + ANG_W'(p_step);
      if (mode_q == LOOP_TRACK) freq_trim <= t_next;
      mode_q <= LOOP_TRACK;
    end
  end
endmodule

// File: rtl/carrier_tracker.sv
module carrier_tracker #(
  parameter int ANG_W    = 16,
  parameter int SYMS     = 4,
  parameter int TRIM_W   = 12,
  parameter int KP_SHIFT = 1,
  parameter int KI_SHIFT = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     resync,
  input  logic                     ang_valid,
  output logic                     ang_ready,
  input  logic [ANG_W-1:0]         ang_data,
  input  logic                     byte_strobe,
  output logic [ANG_W-1:0]         phase_ofs,
  output logic signed [TRIM_W-1:0] freq_trim
);
  localparam int FRAC_W = ANG_W - 2;
  localparam int ERR_W  = FRAC_W + 1;

  logic full, take, apply;
  logic signed [ERR_W-1:0] err;
  logic unused_quadrant;

  assign unused_quadrant = &{1'b0, ang_data[ANG_W-1:FRAC_W]};
  assign ang_ready = !full;
  assign take      = ang_valid && ang_ready;
  assign apply     = byte_strobe && full;

  trk_frac_avg #(.FRAC_W(FRAC_W), .SYMS(SYMS)) avg_i (
    .clk(clk), .rst_n(rst_n), .clr(resync || apply), .take(take),
    .frac(ang_data[FRAC_W-1:0]), .full(full), .err(err)
  );

  trk_loop_filter #(.ANG_W(ANG_W), .ERR_W(ERR_W), .TRIM_W(TRIM_W),
                    .KP_SHIFT(KP_SHIFT), .KI_SHIFT(KI_SHIFT)) filt_i (
    .clk(clk), .rst_n(rst_n), .resync(resync), .apply(apply), .err(err),
    .phase_ofs(phase_ofs), .freq_trim(freq_trim)
  );
endmodule

// File: rtl/carrier_tracker_chk.sv
module carrier_tracker_chk #(
  parameter int ANG_W  = 16,
  parameter int TRIM_W = 12
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     resync,
  input logic                     ang_ready,
  input logic                     byte_strobe,
  input logic [ANG_W-1:0]         phase_ofs,
  input logic signed [TRIM_W-1:0] freq_trim
);
  // R10
  outs_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!byte_strobe && !resync) |=> ($stable(phase_ofs) && $stable(freq_trim)));

  // R8
  short_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_strobe && ang_ready && !resync) |=> ($stable(phase_ofs) && $stable(freq_trim)));

  // R2
  ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ang_ready && !byte_strobe && !resync) |=> !ang_ready);

  // R9
  resync_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resync |=> (freq_trim == '0 && ang_ready && $stable(phase_ofs)));

  // R7
  first_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resync |=> (byte_strobe |=> $stable(freq_trim)));
endmodule

bind carrier_tracker carrier_tracker_chk #(.ANG_W(ANG_W), .TRIM_W(TRIM_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .resync(resync), .ang_ready(ang_ready),
  .byte_strobe(byte_strobe), .phase_ofs(phase_ofs), .freq_trim(freq_trim)
);

// File: tb/carrier_tracker_tb_top.sv
`timescale 1ns/1ps
module carrier_tracker_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic resync = 1'b0;
  logic ang_valid = 1'b0;
  logic ang_ready;
  logic [15:0] ang_data = '0;
  logic byte_strobe = 1'b0;
  logic [15:0] phase_ofs;
  logic signed [11:0] freq_trim;

  int total = 0;
  int bad = 0;
  int m_ph = 0;
  int m_tr = 0;
  bit m_first = 1'b1;

  always #2 clk = ~clk;

  carrier_tracker dut_i (
    .clk(clk), .rst_n(rst_n), .resync(resync), .ang_valid(ang_valid),
    .ang_ready(ang_ready), .ang_data(ang_data), .byte_strobe(byte_strobe),
    .phase_ofs(phase_ofs), .freq_trim(freq_trim)
  );

  // Angles per byte, and the byte error each one must produce (R4)
  localparam logic [15:0] VEC_ANG [7][4] = '{
    '{16'h2000, 16'h6000, 16'hA000, 16'hE000},
    '{16'h2400, 16'h2400, 16'h2400, 16'h2400},
    '{16'h1C00, 16'h5C00, 16'h9C00, 16'hDC00},
    '{16'h0000, 16'h3FFF, 16'h2000, 16'h2000},
    '{16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF},
    '{16'h0000, 16'h4000, 16'h8000, 16'hC000},
    '{16'h2001, 16'h2002, 16'h2000, 16'h2000}
  };
  localparam int VEC_ERR [7] = '{0, 1024, -1024, -1, 8191, -8192, 0};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model(input int e);
    m_ph = (m_ph + (e >>> 1)) & 65535;
    if (!m_first) begin
      m_tr = m_tr + (e >>> 4);
      if (m_tr > 2047) m_tr = 2047;
      if (m_tr < -2048) m_tr = -2048;
    end
    m_first = 1'b0;
  endtask

  task automatic send_sym(input logic [15:0] a);
    @(negedge clk);
    ang_valid = 1'b1;
    ang_data = a;
    @(negedge clk);
    ang_valid = 1'b0;
  endtask

  task automatic strobe();
    @(negedge clk);
    byte_strobe = 1'b1;
    @(negedge clk);
    byte_strobe = 1'b0;
  endtask

  task automatic check_outs(input string req);
    chk(phase_ofs == m_ph[15:0], {req, " phase"}, int'(phase_ofs), m_ph);
    chk(int'(freq_trim) == m_tr, {req, " trim"}, int'(freq_trim), m_tr);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(phase_ofs == 16'd0, "R1 phase", int'(phase_ofs), 0);
    chk(freq_trim == 12'sd0, "R1 trim", int'(freq_trim), 0);
    chk(ang_ready == 1'b1, "R1 ready", int'(ang_ready), 1);
    rst_n = 1'b1;

    // Table walk: R3 quadrant bits vary, R4 R5 error and phase, R6 R7 trim
    for (int v = 0; v < 7; v++) begin
      for (int s = 0; s < 4; s++) send_sym(VEC_ANG[v][s]);
      chk(ang_ready == 1'b0, "R2 ready low when full", int'(ang_ready), 0);
      chk(phase_ofs == m_ph[15:0], "R10 no change before strobe", int'(phase_ofs), m_ph);
      strobe();
      model(VEC_ERR[v]);
      check_outs(v == 0 ? "R7 R3" : "R4 R5 R6");
      chk(ang_ready == 1'b1, "R2 ready after strobe", int'(ang_ready), 1);
    end

    // R2 back-pressure: offered symbols while not ready are not taken
    for (int s = 0; s < 4; s++) send_sym(16'h2400);
    @(negedge clk);
    ang_valid = 1'b1;
    ang_data = 16'h0000;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk(ang_ready == 1'b0, "R2 held off", int'(ang_ready), 0);
    end
    ang_valid = 1'b0;
    strobe();
    model(1024);
    check_outs("R2");

    // R8 short strobe ignored, held symbols kept
    send_sym(16'h2800);
    send_sym(16'h2800);
    strobe();
    check_outs("R8 short strobe");
    chk(ang_ready == 1'b1, "R8 ready", int'(ang_ready), 1);
    send_sym(16'h2800);
    send_sym(16'h2800);
    chk(ang_ready == 1'b0, "R8 count kept", int'(ang_ready), 0);
    strobe();
    model(2048);
    check_outs("R8 R5");

    // R6 positive saturation
    for (int b = 0; b < 5; b++) begin
      for (int s = 0; s < 4; s++) send_sym(16'h3FFF);
      strobe();
      model(8191);
    end
    chk(int'(freq_trim) == 2047, "R6 saturate high", int'(freq_trim), 2047);
    check_outs("R6");

    // R6 negative saturation
    for (int b = 0; b < 9; b++) begin
      for (int s = 0; s < 4; s++) send_sym(16'h0000);
      strobe();
      model(-8192);
    end
    chk(int'(freq_trim) == -2048, "R6 saturate low", int'(freq_trim), -2048);
    check_outs("R6");

    // R9 resync: partial byte dropped, trim cleared, phase kept
    send_sym(16'h3FFF);
    send_sym(16'h3FFF);
    @(negedge clk);
    resync = 1'b1;
    @(negedge clk);
    resync = 1'b0;
    m_tr = 0;
    m_first = 1'b1;
    check_outs("R9");
    chk(ang_ready == 1'b1, "R9 ready", int'(ang_ready), 1);
    for (int s = 0; s < 4; s++) send_sym(16'h2400);
    chk(ang_ready == 1'b0, "R9 partial dropped", int'(ang_ready), 0);
    strobe();
    model(1024);
    check_outs("R7 R9 first byte");
    for (int s = 0; s < 4; s++) send_sym(16'hE400);
    strobe();
    model(1024);
    check_outs("R6 R3 tracking");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule